// File: doc/BRIEF.md
# Fractional-N Serial Clock Generator

This block derives a serial line clock from a fast reference clock. Every reference cycle is one output slot. The output level is held for a whole number of slots and then inverted. A configuration word supplies three fields, A, B and C. Together they define a repeating pattern in two parts. The first part holds (C − B) states that are A slots wide. The second part holds (B + 1) states that are A + 1 slots wide. Mixing the two widths gives an average divide ratio of A + (B + 1)/(C + 1) against half the reference rate, so the average ratio can fall between two integers.

A new word is written by presenting it together with a one-cycle load strobe. The word is held as pending and replaces the active configuration only when the running pattern ends. The output therefore never shows a shortened state. When several words arrive before the pattern ends, the most recent one is used. A word that arrives in the last slot of a pattern governs the very next pattern.

Top module: `frac_clk_gen`

## Requirements
- R1: Field positions in the configuration word are fixed: A is bits [31:22], B is bits [21:12] and C is bits [11:0], all unsigned.
- R2: One pattern consists of (C − B) states of A slots each, then (B + 1) states of A + 1 slots each, and then it repeats. Its length is (C − B)·A + (B + 1)·(A + 1) slots.
- R3: The output inverts at every state boundary, including the boundary between the two parts and the boundary where the pattern repeats. Within a state it holds its level.
- R4: While the synchronous reset is high the output is 0. After reset the configuration is A=2, B=2, C=7. The first slot after reset starts the first A-wide state at level 1, so the output repeats 1100110011000111000.
- R5: If B ≥ C, or if A = 0, the A-wide part holds no states. In that case the pattern consists only of the (B + 1) states of width A + 1. With A=0, B=1, C=1 the output inverts in every slot.
- R6: A word loaded in the middle of a pattern does not change the current pattern. It takes effect from the first slot of the next pattern.
- R7: A word loaded in the cycle whose clock edge starts a new pattern governs that new pattern.
- R8: When several words are loaded within one pattern, only the last one is applied at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle per output slot |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Configuration word carrying the A, B and C fields |
| cfg_load | input | 1 | One-cycle strobe that captures cfg_word |
| line_clk | output | 1 | Generated line clock level |

## Verification
Two events can fall on the same clock edge: a configuration load, and the pattern boundary at which a pending word is applied. The bench keeps its own slot queue built from the requirements. It waits until that queue is empty, which marks the final slot of a pattern, and strobes a new word on exactly that edge. The following slots must then follow the new word with no gap. Random loads at random times cover the same collision and its neighbours: loads one slot before the boundary, one slot after it, and more than one load within a single pattern.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
    parameter int unsigned FC_A_W = 10;
    parameter int unsigned FC_B_W = 10;
    parameter int unsigned FC_C_W = 12;
    localparam int unsigned FC_CFG_W = FC_A_W + FC_B_W + FC_C_W;
    localparam int unsigned FC_ST_W  = (FC_C_W > FC_B_W) ? FC_C_W : FC_B_W;

    // packed order puts A in the top bits and C in the bottom bits
    typedef struct packed {
        logic [FC_A_W-1:0] a;
        logic [FC_B_W-1:0] b;
        logic [FC_C_W-1:0] c;
    } fc_cfg_t;

    function automatic fc_cfg_t fc_unpack(input logic [FC_CFG_W-1:0] w);
        return fc_cfg_t'(w);
    endfunction
endpackage

// File: rtl/frac_clk_cfg.sv
module frac_clk_cfg
    import frac_clk_pkg::*;
#(
    parameter logic [FC_CFG_W-1:0] RST_WORD = 32'h0080_2007
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [FC_CFG_W-1:0] word,
    input  logic                load,
    input  logic                boundary,
    output fc_cfg_t             cfg_next,
    output fc_cfg_t             cfg_act
);
    typedef struct packed {
        fc_cfg_t act;
        fc_cfg_t pend;
        logic    pend_vld;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    fc_cfg_t word_cfg;

    always_comb begin
        word_cfg = fc_unpack(word);
        // a load on the boundary edge bypasses the pending slot
        cfg_next = load ? word_cfg : (st_q.pend_vld ? st_q.pend : st_q.act);
        st_d = st_q;
        if (boundary) begin
            st_d.act      = cfg_next;
            st_d.pend_vld = 1'b0;
        end else if (load) begin
            st_d.pend     = word_cfg;
            st_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.act      <= fc_unpack(RST_WORD);
            st_q.pend     <= '0;
            st_q.pend_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_act = st_q.act;

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(cfg_act));

    // R8
    last_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !boundary) |=> (load || cfg_next == $past(word_cfg)));
endmodule

// File: rtl/frac_clk_seq.sv
module frac_clk_seq
    import frac_clk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fc_cfg_t cfg_next,
    input  fc_cfg_t cfg_act,
    output logic    boundary,
    output logic    level
);
    typedef struct packed {
        logic               fresh;
        logic               phase_b;
        logic [FC_A_W-1:0]  slot;
        logic [FC_ST_W-1:0] cnt;
        logic               level;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    grp_a_nonempty;

    always_comb begin
        boundary = s_q.fresh | (s_q.phase_b && s_q.cnt == '0 && s_q.slot == '0);
        grp_a_nonempty = (cfg_next.a != '0) && (cfg_next.c > FC_C_W'(cfg_next.b));
        s_d = s_q;
        s_d.fresh = 1'b0;
        if (boundary) begin
            s_d.level = ~s_q.level;
            if (grp_a_nonempty) begin
                s_d.phase_b = 1'b0;
                s_d.cnt     = FC_ST_W'(cfg_next.c) - FC_ST_W'(cfg_next.b) - FC_ST_W'(1);
                s_d.slot    = cfg_next.a - FC_A_W'(1);
            end else begin
                s_d.phase_b = 1'b1;
                s_d.cnt     = FC_ST_W'(cfg_next.b);
                s_d.slot    = cfg_next.a;
            end
        end else if (s_q.slot == '0) begin
            s_d.level = ~s_q.level;
            if (!s_q.phase_b && s_q.cnt == '0) begin
                s_d.phase_b = 1'b1;
                s_d.cnt     = FC_ST_W'(cfg_act.b);
                s_d.slot    = cfg_act.a;
            end else begin
                s_d.cnt  = s_q.cnt - FC_ST_W'(1);
                s_d.slot = s_q.phase_b ? cfg_act.a : cfg_act.a - FC_A_W'(1);
            end
        end else begin
            s_d.slot = s_q.slot - FC_A_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.fresh   <= 1'b1;
            s_q.phase_b <= 1'b0;
            s_q.slot    <= '0;
            s_q.cnt     <= '0;
            s_q.level   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.level;

    // R3
    hold_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (!boundary && s_q.slot != '0) |=> $stable(level));

    // R3
    toggle_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary || s_q.slot == '0) |=> (level != $past(level)));

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        !s_q.fresh |-> (s_q.slot <= cfg_act.a));

    // R5
    skip_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (!s_q.fresh && !s_q.phase_b) |->
            (cfg_act.a != '0 && cfg_act.c > FC_C_W'(cfg_act.b)));
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen
    import frac_clk_pkg::*;
#(
    parameter logic [FC_CFG_W-1:0] RST_WORD = 32'h0080_2007
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [FC_CFG_W-1:0] cfg_word,
    input  logic                cfg_load,
    output logic                line_clk
);
    fc_cfg_t cfg_next, cfg_act;
    logic    boundary;

    frac_clk_cfg #(.RST_WORD(RST_WORD)) i_cfg (
        .clk      (clk),
        .rst      (rst),
        .word     (cfg_word),
        .load     (cfg_load),
        .boundary (boundary),
        .cfg_next (cfg_next),
        .cfg_act  (cfg_act)
    );

    frac_clk_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .cfg_next (cfg_next),
        .cfg_act  (cfg_act),
        .boundary (boundary),
        .level    (line_clk)
    );

    // R4
    rst_low_chk: assert property (@(posedge clk) rst |=> !line_clk);

    // R4
    first_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(rst)) |=> line_clk);
endmodule

// File: tb/test_frac_clk_gen.sv
module test_frac_clk_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        cfg_load = 1'b0;
    logic        line_clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [31:0] DEF_WORD = 32'h0080_2007;

    always #10 clk = ~clk;

    frac_clk_gen i_frac_clk_gen (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .cfg_load(cfg_load), .line_clk(line_clk)
    );

    // bench model state
    bit          mq[$];
    bit          mlevel;
    logic [31:0] m_act, m_pend;
    bit          m_pv;
    bit          exp_bit;

    function automatic logic [31:0] mk(int a, int b, int c);
        return (32'(a) << 22) | (32'(b) << 12) | 32'(c);
    endfunction

    task automatic fill(logic [31:0] w);
        int a = int'(w[31:22]);
        int b = int'(w[21:12]);
        int c = int'(w[11:0]);
        int na = (a != 0 && c > b) ? c - b : 0;
        for (int i = 0; i < na; i++) begin
            mlevel = ~mlevel;
            for (int k = 0; k < a; k++) mq.push_back(mlevel);
        end
        for (int i = 0; i <= b; i++) begin
            mlevel = ~mlevel;
            for (int k = 0; k <= a; k++) mq.push_back(mlevel);
        end
    endtask

    task automatic model_edge(bit ld, logic [31:0] w);
        logic [31:0] sel;
        if (mq.size() == 0) begin
            sel   = ld ? w : (m_pv ? m_pend : m_act);
            m_pv  = 0;
            m_act = sel;
            fill(sel);
        end else if (ld) begin
            m_pend = w;
            m_pv   = 1;
        end
        exp_bit = mq.pop_front();
    endtask

    task automatic check(bit ok, string tag, logic act, logic exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: line_clk=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negedge; drives inputs, advances one edge, checks
    task automatic tick(bit ld, logic [31:0] w, string tag);
        cfg_load = ld;
        cfg_word = w;
        model_edge(ld, w);
        @(negedge clk);
        cfg_load = 1'b0;
        check(line_clk === exp_bit, tag, line_clk, exp_bit);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) tick(1'b0, '0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(line_clk === 1'b0, "R4 reset low", line_clk, 1'b0);
        rst = 1'b0;
        mq.delete();
        mlevel = 0;
        m_act  = DEF_WORD;
        m_pv   = 0;
    endtask

    task automatic to_boundary(string tag);
        while (mq.size() != 0) tick(1'b0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: line_clk=%b expected run end", line_clk);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [18:0] got;
        logic        prev;
        void'($urandom(32'd4711));
        do_reset();

        // R4: default pattern straight after reset, judged against a constant
        for (int i = 18; i >= 0; i--) begin
            tick(1'b0, '0, "R4 default");
            got[i] = line_clk;
        end
        n_chk++;
        if (got !== 19'b1100110011000111000) begin
            n_fail++;
            $display("FAIL R4 pattern: line_clk=%b expected %b", got, 19'b1100110011000111000);
        end
        run(19, "R4 repeat");

        // R6: mid-pattern load, old pattern completes first
        run(5, "R6");
        tick(1'b1, mk(1, 0, 2), "R6 load mid");
        to_boundary("R6 old pattern");
        run(20, "R1 R2 new fields");

        // R7: load on the boundary edge
        to_boundary("R7 approach");
        tick(1'b1, mk(3, 1, 4), "R7 load at boundary");
        run(40, "R7 applied");

        // R8: two loads in one pattern
        run(2, "R8");
        tick(1'b1, mk(2, 0, 5), "R8 first load");
        run(1, "R8");
        tick(1'b1, mk(1, 2, 6), "R8 second load");
        to_boundary("R8 drain");
        run(30, "R8 last wins");

        // R5: divide by one, toggles each slot
        tick(1'b1, mk(0, 1, 1), "R5 load");
        to_boundary("R5 drain");
        run(2, "R5");
        prev = line_clk;
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, '0, "R5 unit");
            check(line_clk !== prev, "R5 toggle each slot", line_clk, ~prev);
            prev = line_clk;
        end
        // R5: B above C, A-wide part skipped
        tick(1'b1, mk(3, 5, 2), "R5 load b>c");
        to_boundary("R5 drain");
        run(60, "R5 b>c");
        tick(1'b1, mk(0, 2, 6), "R5 load a=0");
        to_boundary("R5 drain");
        run(20, "R5 a=0");

        // R2: extremes of field range
        tick(1'b1, mk(1023, 0, 0), "R2 load max a");
        to_boundary("R2 drain");
        run(2100, "R2 max a");
        tick(1'b1, mk(1, 0, 4095), "R2 load max c");
        to_boundary("R2 drain");
        run(4200, "R2 max c");
        tick(1'b1, mk(2, 1023, 1023), "R2 load max b");
        to_boundary("R2 drain");
        run(3200, "R2 max b");

        // R2 R3 R6 R7 R8: random small configs at random times
        for (int i = 0; i < 6000; i++) begin
            bit ld = ($urandom_range(0, 29) == 0);
            logic [31:0] w = mk($urandom_range(0, 4), $urandom_range(0, 9),
                                $urandom_range(0, 12));
            tick(ld, w, "R2 R3 random");
        end

        // R4: reset in mid run
        do_reset();
        run(38, "R4 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule